// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the master of a single-wire, wired-OR serial interrupt line that runs on the bus clock. Each transfer opens with a Start pulse, which the host drives either of its own accord or as a continuation of a one-clock low pulse from a slave. A train of three-clock data frames follows, and each frame gives one slave signal a slot in which it pulls the line low when its source is asserted. The host closes the transfer with a Stop pulse. The width of that pulse tells every agent whether the next transfer may be opened by any agent (Quiet mode) or only by the host (Continuous mode).

The host registers the line level at the end of every frame's sample clock and presents it on a parallel vector, one bit per frame. The software-visible settings arrive as plain inputs: the Start width code, the frame count code, the Stop mode request and a minimum number of idle clocks between transfers. The line leaves the block as an enable and value pair and comes back as a single input.

Top module: `sirq_host`

## Requirements
- R1: While reset is low and just after it, line_oe is 0, frame_q is all ones and the mode is Continuous. The host then opens the first transfer on its own, with its first low clock following the G-th rising edge after reset release. G is idle_gap, and a value of 0 counts as 1.
- R2: A Start that the host opens drives line_oe=1 and line_drv=0 for W clocks. W is 4, 6 or 8 for width_sel 00, 01 or 10, and code 11 also gives 8. One clock with line_oe=1 and line_drv=1 follows, and then the host releases the line.
- R3: In Quiet mode, a low on line_in during a permitted idle clock, with the host not driving, starts a transfer. The host drives low from the next clock so that the total low time is W, and it does not drive during the slave's clock.
- R4: Clock 0 is the Start's driven-high clock. Frame N samples in clock 3N-1, and line_in is captured at the end of that clock. The host keeps line_oe at 0 from clock 1 to the turn-around clock of the last frame.
- R5: frames_sel code c gives 17+c frames, so code 0000 gives 17 and code 1111 gives 32. The Stop's first low clock is clock 3(17+c)+2.
- R6: The Stop is 2 low clocks when quiet_next is 1 on the edge that begins it, and 3 low clocks otherwise. The next transfer then runs in Quiet or Continuous mode to match. One driven-high clock follows, and then the host releases the line.
- R7: In Continuous mode the host opens the next Start after exactly G released idle clocks following the Stop's high clock, with 0 counted as 1. A low on line_in during idle has no effect.
- R8: In Quiet mode the host opens a Start only while host_kick is high, and then in the clock after the edge that sees it, provided G idle clocks have passed. A slave low in the first idle clock (the turn-around) is ignored. From the second idle clock on, a slave low is accepted as in R3.
- R9: Bit N-1 of frame_q holds frame N's last sample, with 1 meaning the line was high. Only that bit changes, and only on the edge that ends frame N's sample clock. Bits for frames beyond the count keep their values. Bit 2 carries the system-management request, bit 16 the I/O check, bits 17 to 20 the PCI INTA# to INTD# lines, and the other low bits the legacy IRQ numbers in order.
- R10: width_sel and frames_sel are taken on the edge on which a Start begins. Changing them later in a transfer affects only the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level of the shared interrupt line |
| host_kick | input | 1 | Host request to open a transfer in Quiet mode |
| quiet_next | input | 1 | 1 selects a 2-clock (Quiet) Stop, 0 a 3-clock (Continuous) Stop |
| width_sel | input | 2 | Start low width code |
| frames_sel | input | 4 | Frame count code, 17 plus the code |
| idle_gap | input | GAP_W | Minimum idle clocks before the host opens a Start |
| line_oe | output | 1 | Host drives the line when 1 |
| line_drv | output | 1 | Value driven while line_oe is 1 |
| frame_q | output | FRAMES_MAX | Last sampled level of each frame |

## Verification
The bench plays slave agents that pull the line low only within the exact sample clock of a chosen frame. A controller that samples one clock early or late therefore registers high where a zero is expected. It sends slave pulses in the turn-around clock and in Continuous-mode idle time. A design that accepts them opens a Start early, and line_oe shows it in the very next clock. It changes the width and frame-count codes partway through a transfer, which catches a design that reads them live and ends the Stop at the wrong clock. It also counts the low clocks of slave-begun Starts, which exposes a host that adds its full width on top of the slave's clock, and the idle gap with a code of zero, which exposes a host that restarts with no turn-around at all.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  // Smallest frame count a transfer may carry; the 4-bit code adds to it.
  localparam int unsigned MIN_FRAMES = 17;

  typedef enum logic [2:0] {
    ST_IDLE,   // line released, counting idle clocks
    ST_SLO,    // Start low, host driving
    ST_SHI,    // Start driven high (clock 0 of frame timing)
    ST_STA,    // Start turn-around
    ST_FRM,    // data frames: sample, recovery, turn-around
    ST_PLO,    // Stop low
    ST_PHI     // Stop driven high
  } sirq_st_e;

  // Total Start low clocks for a width code; the spare code maps to the widest.
  function automatic logic [3:0] start_clocks(input logic [1:0] sel);
    case (sel)
      2'b00:   return 4'd4;
      2'b01:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  // Number of frames carried for a frame-count code.
  function automatic logic [5:0] frame_total(input logic [3:0] code);
    return 6'(MIN_FRAMES) + {2'b00, code};
  endfunction

  // Stop low clocks: short for Quiet, long for Continuous.
  function automatic logic [1:0] stop_clocks(input logic quiet);
    return quiet ? 2'd2 : 2'd3;
  endfunction

endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int unsigned FRAMES_MAX = 32,
  parameter int unsigned GAP_W      = 4,
  localparam int unsigned IDX_W     = $clog2(FRAMES_MAX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_in,
  input  logic             host_kick,
  input  logic             quiet_req,
  input  logic [1:0]       width_sel,
  input  logic [3:0]       frames_sel,
  input  logic [GAP_W-1:0] gap_min,
  output logic             drive_en,
  output logic             drive_val,
  output logic             samp_stb,
  output logic [IDX_W-1:0] samp_idx,
  output logic             quiet_q,
  output logic             host_go,
  output logic             slave_go
);

  sirq_st_e         st;
  logic [2:0]       lo_left;
  logic [1:0]       ph;
  logic [IDX_W-1:0] fidx;
  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] new_last;
  logic [GAP_W-1:0] idle_cnt;
  logic [GAP_W-1:0] gap_eff;
  logic [3:0]       sw;
  logic [5:0]       tot;
  logic [5:0]       tot_lim;
  logic             idle_ok;

  always_comb begin
    sw       = start_clocks(width_sel);
    tot      = frame_total(frames_sel);
    tot_lim  = (tot > 6'(FRAMES_MAX)) ? 6'(FRAMES_MAX) : tot;
    new_last = IDX_W'(tot_lim - 6'd1);
    gap_eff  = (gap_min == '0) ? GAP_W'(1) : gap_min;
    idle_ok  = idle_cnt >= (gap_eff - GAP_W'(1));
    // a slave may only open in Quiet mode, never in the turn-around clock
    slave_go = (st == ST_IDLE) && quiet_q && (idle_cnt != '0) && !bus_in;
    host_go  = (st == ST_IDLE) && !slave_go && idle_ok && (!quiet_q || host_kick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      lo_left  <= '0;
      ph       <= '0;
      fidx     <= '0;
      last_idx <= '0;
      idle_cnt <= '0;
      quiet_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (slave_go || host_go) begin
            st       <= ST_SLO;
            // the slave's own low clock counts toward the width
            lo_left  <= slave_go ? 3'(sw - 4'd2) : 3'(sw - 4'd1);
            last_idx <= new_last;
          end else if (idle_cnt != '1) begin
            idle_cnt <= idle_cnt + GAP_W'(1);
          end
        end
        ST_SLO: begin
          if (lo_left == 3'd0) st <= ST_SHI;
          else lo_left <= lo_left - 3'd1;
        end
        ST_SHI: st <= ST_STA;
        ST_STA: begin
          st   <= ST_FRM;
          ph   <= 2'd0;
          fidx <= '0;
        end
        ST_FRM: begin
          if (ph == 2'd2) begin
            ph <= 2'd0;
            if (fidx == last_idx) begin
              st      <= ST_PLO;
              lo_left <= 3'(stop_clocks(quiet_req) - 2'd1);
              quiet_q <= quiet_req;
            end else begin
              fidx <= fidx + IDX_W'(1);
            end
          end else begin
            ph <= ph + 2'd1;
          end
        end
        ST_PLO: begin
          if (lo_left == 3'd0) st <= ST_PHI;
          else lo_left <= lo_left - 3'd1;
        end
        ST_PHI: begin
          st       <= ST_IDLE;
          idle_cnt <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign drive_en  = (st == ST_SLO) || (st == ST_SHI) || (st == ST_PLO) || (st == ST_PHI);
  assign drive_val = (st == ST_SHI) || (st == ST_PHI);
  assign samp_stb  = (st == ST_FRM) && (ph == 2'd0);
  assign samp_idx  = fidx;

endmodule

// File: rtl/sirq_capture.sv
module sirq_capture #(
  parameter int unsigned FRAMES_MAX = 32,
  localparam int unsigned IDX_W     = $clog2(FRAMES_MAX)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_in,
  input  logic                  stb,
  input  logic [IDX_W-1:0]      idx,
  output logic [FRAMES_MAX-1:0] q
);

  for (genvar i = 0; i < FRAMES_MAX; i++) begin : g_slot
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b1;
      else if (stb && (idx == IDX_W'(i))) bit_q <= bus_in;
    end
    assign q[i] = bit_q;
  end

endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int unsigned FRAMES_MAX = 32,
  parameter int unsigned GAP_W      = 4,
  localparam int unsigned IDX_W     = $clog2(FRAMES_MAX)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_in,
  input  logic                  host_kick,
  input  logic                  quiet_next,
  input  logic [1:0]            width_sel,
  input  logic [3:0]            frames_sel,
  input  logic [GAP_W-1:0]      idle_gap,
  output logic                  line_oe,
  output logic                  line_drv,
  output logic [FRAMES_MAX-1:0] frame_q
);

  // named internal events, watched by the bound checker
  logic             samp_stb;
  logic [IDX_W-1:0] samp_idx;
  logic             mode_quiet;
  logic             host_go;
  logic             slave_go;

  sirq_seq #(.FRAMES_MAX(FRAMES_MAX), .GAP_W(GAP_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_in     (line_in),
    .host_kick  (host_kick),
    .quiet_req  (quiet_next),
    .width_sel  (width_sel),
    .frames_sel (frames_sel),
    .gap_min    (idle_gap),
    .drive_en   (line_oe),
    .drive_val  (line_drv),
    .samp_stb   (samp_stb),
    .samp_idx   (samp_idx),
    .quiet_q    (mode_quiet),
    .host_go    (host_go),
    .slave_go   (slave_go)
  );

  sirq_capture #(.FRAMES_MAX(FRAMES_MAX)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_in (line_in),
    .stb    (samp_stb),
    .idx    (samp_idx),
    .q      (frame_q)
  );

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
  parameter int unsigned FRAMES_MAX = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  line_oe,
  input logic                  line_drv,
  input logic                  host_kick,
  input logic                  samp_stb,
  input logic                  mode_quiet,
  input logic                  host_go,
  input logic                  slave_go,
  input logic [FRAMES_MAX-1:0] frame_q
);

  // R4: the host never drives during a sample clock
  a_r4_released_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    samp_stb |-> !line_oe);

  // R2, R6: a driven-high clock is always followed by release
  a_r2_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    (line_oe && line_drv) |=> !line_oe);

  // R3: after a slave opens, the host continues the low pulse
  a_r3_host_continues_low: assert property (@(posedge clk) disable iff (!rst_n)
    slave_go |=> (line_oe && !line_drv));

  // R7: slaves cannot open a transfer in Continuous mode
  a_r7_slave_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slave_go |-> mode_quiet);

  // R8: in Quiet mode the host opens only on request
  a_r8_quiet_host_needs_kick: assert property (@(posedge clk) disable iff (!rst_n)
    (host_go && mode_quiet) |-> host_kick);

  // R9: the parallel outputs move only after a sample strobe
  a_r9_change_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(samp_stb) |-> $stable(frame_q));

  // R9: at most one slot changes per clock
  a_r9_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(frame_q ^ $past(frame_q)) <= 1);

endmodule

bind sirq_host sirq_host_chk #(.FRAMES_MAX(FRAMES_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_oe    (line_oe),
  .line_drv   (line_drv),
  .host_kick  (host_kick),
  .samp_stb   (samp_stb),
  .mode_quiet (mode_quiet),
  .host_go    (host_go),
  .slave_go   (slave_go),
  .frame_q    (frame_q)
);

// File: tb/sirq_host_tb_top.sv
module sirq_host_tb_top;

  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned FMAX       = 32;
  localparam int unsigned GW         = 4;
  localparam int          NVEC       = 5;

  // {width code, frame code, slave data (bit N-1 = frame N, 0 = pulled low)}
  localparam logic [37:0] VECS [0:NVEC-1] = '{
    {2'b00, 4'h0, 32'hFFFF_FFFB},
    {2'b01, 4'hF, 32'h0000_0000},
    {2'b10, 4'h5, 32'hAAAA_5555},
    {2'b11, 4'h3, 32'hFFFE_7FFF},
    {2'b00, 4'hF, 32'hFFFF_FFFF}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            host_kick = 1'b0;
  logic            quiet_next = 1'b0;
  logic            slv_low = 1'b0;
  logic [1:0]      width_sel = 2'b00;
  logic [3:0]      frames_sel = 4'h0;
  logic [GW-1:0]   idle_gap = '0;
  logic            line_in;
  logic            line_oe;
  logic            line_drv;
  logic [FMAX-1:0] frame_q;
  logic [FMAX-1:0] exp_q = '1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // wired-OR line with pull-up: host drive wins, else any slave pulls low
  assign line_in = line_oe ? line_drv : ~slv_low;

  sirq_host #(.FRAMES_MAX(FMAX), .GAP_W(GW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_in    (line_in),
    .host_kick  (host_kick),
    .quiet_next (quiet_next),
    .width_sel  (width_sel),
    .frames_sel (frames_sel),
    .idle_gap   (idle_gap),
    .line_oe    (line_oe),
    .line_drv   (line_drv),
    .frame_q    (frame_q)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int exp_width(input logic [1:0] sel);
    return (sel == 2'b11) ? 8 : 4 + 2 * int'(sel);
  endfunction

  function automatic int exp_frames(input logic [3:0] code);
    return 17 + int'(code);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  // From the last negedge, count released idle clocks until the line goes low.
  task automatic wait_start(input int exp_idle, input string req);
    int idle = 0;
    @(negedge clk);
    while (line_in && idle < 200) begin
      idle++;
      @(negedge clk);
    end
    chk(idle == exp_idle, req, "idle clocks before Start", 64'(idle), 64'(exp_idle));
    chk(line_oe && !line_drv, req, "host drives Start low", {62'd0, line_oe, line_drv}, 64'h2);
  endtask

  // Standing in a low clock, count low clocks; ends in the driven-high clock.
  task automatic measure_low(output int len);
    len = 1;
    @(negedge clk);
    while (!line_in && len < 40) begin
      len++;
      @(negedge clk);
    end
  endtask

  // Standing in the Start's high clock (clock 0): play slaves, check frames and Stop.
  task automatic run_body(input int n, input int stop_len, input logic [FMAX-1:0] data,
                          input string pos_req);
    int s;
    chk(line_oe && line_drv, "R2", "Start high clock driven", {62'd0, line_oe, line_drv}, 64'h3);
    for (int k = 1; k <= 3 * n + 1; k++) begin
      @(negedge clk);
      if (k % 3 == 0) begin
        slv_low = 1'b0;
        exp_q[k/3-1] = data[k/3-1];
      end
      chk(!line_oe, "R4", "host released during frames", 64'(line_oe), 64'd0);
      chk(frame_q == exp_q, "R9", "frame outputs", 64'(frame_q), 64'(exp_q));
      if (k % 3 == 2) slv_low = ~data[(k+1)/3-1];
    end
    @(negedge clk);
    chk(!line_in && line_oe, pos_req, "Stop begins after last frame", 64'(line_in), 64'd0);
    s = 0;
    while (!line_in && s < 10) begin
      s++;
      @(negedge clk);
    end
    chk(s == stop_len, "R6", "Stop low clocks", 64'(s), 64'(stop_len));
    chk(line_oe && line_drv, "R6", "Stop high clock driven", {62'd0, line_oe, line_drv}, 64'h3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int len;
    width_sel  = VECS[0][37:36];
    frames_sel = VECS[0][35:32];
    repeat (4) @(negedge clk);
    chk(!line_oe, "R1", "line released in reset", 64'(line_oe), 64'd0);
    chk(frame_q == '1, "R1", "frame outputs in reset", 64'(frame_q), 64'(exp_q));
    rst_n = 1'b1;

    // Table walk: Continuous mode, host-opened transfers, config changed mid-cycle (R10)
    for (int i = 0; i < NVEC; i++) begin
      int w;
      int n;
      int nxt;
      w   = exp_width(VECS[i][37:36]);
      n   = exp_frames(VECS[i][35:32]);
      nxt = (i < NVEC - 1) ? i + 1 : i;
      wait_start((i == 0) ? 0 : 1, (i == 0) ? "R1" : "R7");
      measure_low(len);
      chk(len == w, "R2", "Start low clocks", 64'(len), 64'(w));
      width_sel  = VECS[nxt][37:36];
      frames_sel = VECS[nxt][35:32];
      run_body(n, 3, VECS[i][31:0], (i == 0) ? "R5" : "R10");
    end

    // R7: gap of 6, a slave low in idle is ignored in Continuous mode
    idle_gap   = 4'd6;
    quiet_next = 1'b1;
    width_sel  = 2'b01;
    frames_sel = 4'h0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 4) slv_low = 1'b0;
      chk(!line_oe, "R7", "no Start inside gap", 64'(line_oe), 64'd0);
      if (k == 3) slv_low = 1'b1;
    end
    @(negedge clk);
    chk(line_oe && !line_drv, "R7", "host Start after gap", {62'd0, line_oe, line_drv}, 64'h2);
    measure_low(len);
    chk(len == 6, "R2", "Start low clocks", 64'(len), 64'd6);
    run_body(17, 2, 32'h0001_2345, "R5");

    // R8 and R3: Quiet mode, turn-around pulse ignored, later slave pulse opens
    idle_gap   = 4'd1;
    width_sel  = 2'b10;
    frames_sel = 4'h1;
    @(negedge clk);
    slv_low = 1'b1;
    @(negedge clk);
    slv_low = 1'b0;
    chk(!line_oe, "R8", "turn-around slave low ignored", 64'(line_oe), 64'd0);
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      chk(!line_oe && line_in, "R8", "no host Start without request", 64'(line_oe), 64'd0);
    end
    @(negedge clk);
    slv_low = 1'b1;
    chk(!line_oe, "R3", "host silent in slave clock", 64'(line_oe), 64'd0);
    @(negedge clk);
    slv_low = 1'b0;
    chk(line_oe && !line_drv, "R3", "host continues low", {62'd0, line_oe, line_drv}, 64'h2);
    measure_low(len);
    chk(len + 1 == 8, "R3", "total low of slave Start", 64'(len + 1), 64'd8);
    run_body(18, 2, 32'hFFFC_F0F0, "R5");

    // R8: host request opens a transfer in Quiet mode
    quiet_next = 1'b0;
    width_sel  = 2'b00;
    frames_sel = 4'h2;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!line_oe, "R8", "idle before request", 64'(line_oe), 64'd0);
    end
    host_kick = 1'b1;
    @(negedge clk);
    chk(line_oe && !line_drv, "R8", "request opens Start", {62'd0, line_oe, line_drv}, 64'h2);
    host_kick = 1'b0;
    measure_low(len);
    chk(len == 4, "R2", "Start low clocks", 64'(len), 64'd4);
    run_body(19, 3, 32'h0005_5AA5, "R5");

    // R7 back in Continuous mode, then R1 reset in mid-transfer
    frames_sel = 4'h0;
    wait_start(1, "R7");
    measure_low(len);
    chk(len == 4, "R2", "Start low clocks", 64'(len), 64'd4);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    exp_q = '1;
    chk(!line_oe, "R1", "line released in reset", 64'(line_oe), 64'd0);
    chk(frame_q == exp_q, "R1", "frame outputs in reset", 64'(frame_q), 64'(exp_q));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait_start(0, "R1");
    measure_low(len);
    chk(len == 4, "R1", "first Start after reset", 64'(len), 64'd4);
    run_body(17, 3, 32'hFFFF_FFFF, "R5");

    finish_up();
  end

endmodule